// File: doc/BRIEF.md
# Cascaded Tick Timer with Toggle Latch

This block produces a slow periodic event from a fast clock enable. A free-running 16-bit prescaler advances once per active cycle of a 10 MHz enable. When it passes from all-ones back to zero it emits a one-cycle tick, which happens roughly every 6.55 ms. Each tick inverts a toggle flip-flop. The toggle's level replaces one bit of an input-port vector that goes to an external controller. That controller watches the bit for changes and raises an interrupt on each change. Because the latch changes level once per tick instead of pulsing, the controller sees one edge per tick.

A second counter, cascaded after the prescaler, counts ticks. Software reads it through a simple zero-wait read port at one fixed word address. Read data is registered and appears on the cycle after the strobe. A read of any other address returns zero.

Top module: `tick_toggle_timer`

## Requirements
- R1: A synchronous active-high `rst` clears the prescaler, the toggle latch, the tick counter and `rd_data` to 0. After reset the first tick comes after exactly 2^PRE_W enabled cycles.
- R2: The prescaler advances by one only in cycles where `cnt_en` is 1. `tick` is 1 exactly in a cycle where `cnt_en` is 1 and the prescaler holds all ones, and is 0 in every other cycle.
- R3: `tick` is never 1 in two consecutive cycles, even when `cnt_en` is held high.
- R4: The toggle latch inverts on the clock edge that ends a tick cycle and holds its level otherwise. Its level appears on bit TOGGLE_BIT (default 2) of `ip_out`.
- R5: Every bit of `ip_out` other than TOGGLE_BIT equals the same bit of `ip_in` in the same cycle.
- R6: The tick counter is TCNT_W bits wide. It increments by one on each tick and wraps from all ones to 0 without saturating.
- R7: When `rd_stb` is 1 and `rd_addr` equals CNT_ADDR (default 0x30), `rd_data` on the next cycle equals the tick count as it stood in the strobe cycle, zero-extended to DATA_W. `rd_data` holds its value in cycles without a strobe.
- R8: When `rd_stb` is 1 and `rd_addr` differs from CNT_ADDR, `rd_data` on the next cycle is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | 10 MHz count enable for the prescaler |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Word address of the read |
| ip_in | input | PORT_W | Input-port bits that pass through to the controller |
| tick | output | 1 | One-cycle pulse at prescaler wrap |
| ip_out | output | PORT_W | Input-port vector with the toggle level in bit TOGGLE_BIT |
| rd_data | output | DATA_W | Registered read data |

## Verification
Suppose the prescaler skips or repeats a state. The first tick then arrives early or late, and it shows on `tick` within one prescaler period, which is 16 enabled cycles in the reduced bench build. A wrong toggle state shows at once and lasts on `ip_out` bit 2, and it stays inverted until the next reset. A miscounting tick counter shows only when software reads it, one cycle after a strobe. The bench therefore reads often and makes the counter wrap several times.

// File: rtl/tt_pkg.sv
package tt_pkg;

  // Next level of a toggle latch given a flip request.
  function automatic logic tt_toggle_next(input logic q, input logic flip);
    return q ^ flip;
  endfunction

  // A read captures the counter only on a strobe that hits the mapped address.
  function automatic logic tt_rd_select(input logic stb, input logic hit);
    return stb & hit;
  endfunction

endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] pre_q,
  output logic         tick
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  function automatic logic at_terminal(input logic [W-1:0] v);
    return &v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)     pre_q <= '0;
    else if (en) pre_q <= pre_q + ONE;
  end

  assign tick = en & at_terminal(pre_q);
endmodule

// File: rtl/tt_toggle.sv
module tt_toggle (
  input  logic clk,
  input  logic rst,
  input  logic flip,
  output logic q
);
  import tt_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= tt_toggle_next(q, flip);
  end
endmodule

// File: rtl/tt_tick_counter.sv
module tt_tick_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (inc) cnt <= cnt + ONE;
  end
endmodule

// File: rtl/tt_read_port.sv
module tt_read_port #(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 16,
  parameter int              CNT_W    = 16,
  parameter logic [ADDR_W-1:0] CNT_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] data
);
  import tt_pkg::*;

  logic hit;
  assign hit = (addr == CNT_ADDR);

  always_ff @(posedge clk) begin
    if (rst)                       data <= '0;
    else if (tt_rd_select(stb, hit)) data <= DATA_W'(cnt);
    else if (stb)                  data <= '0;
  end
endmodule

// File: rtl/tick_toggle_timer.sv
module tick_toggle_timer #(
  parameter int              PRE_W      = 16,
  parameter int              TCNT_W     = 16,
  parameter int              DATA_W     = 16,
  parameter int              ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CNT_ADDR = 8'h30,
  parameter int              PORT_W     = 6,
  parameter int              TOGGLE_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [PORT_W-1:0] ip_in,
  output logic              tick,
  output logic [PORT_W-1:0] ip_out,
  output logic [DATA_W-1:0] rd_data
);
  logic [PRE_W-1:0]  pre;
  logic [TCNT_W-1:0] tcnt;
  logic              toggle_q;

  tt_prescaler #(.W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .en(cnt_en), .pre_q(pre), .tick(tick)
  );

  tt_toggle u_tog (
    .clk(clk), .rst(rst), .flip(tick), .q(toggle_q)
  );

  tt_tick_counter #(.W(TCNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(tick), .cnt(tcnt)
  );

  tt_read_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(TCNT_W), .CNT_ADDR(CNT_ADDR)
  ) u_rd (
    .clk(clk), .rst(rst), .stb(rd_stb), .addr(rd_addr), .cnt(tcnt), .data(rd_data)
  );

  // Replace one bit of the port vector with the toggle level.
  for (genvar i = 0; i < PORT_W; i++) begin : g_port
    if (i == TOGGLE_BIT) begin : g_tog
      assign ip_out[i] = toggle_q;
    end else begin : g_pass
      assign ip_out[i] = ip_in[i];
    end
  end
endmodule

// File: rtl/tick_toggle_timer_chk.sv
module tick_toggle_timer_chk #(
  parameter int              PRE_W    = 16,
  parameter int              TCNT_W   = 16,
  parameter int              DATA_W   = 16,
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CNT_ADDR = 8'h30
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_en,
  input logic              rd_stb,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              tick,
  input logic              toggle_q,
  input logic [PRE_W-1:0]  pre,
  input logic [TCNT_W-1:0] tcnt,
  input logic [DATA_W-1:0] rd_data
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (pre == '0 && tcnt == '0 && !toggle_q && rd_data == '0)); // R1
  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst) tick |-> cnt_en); // R2
  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (rst) !cnt_en |=> $stable(pre)); // R2
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst) tick |=> !tick); // R3
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (rst) tick |=> (toggle_q != $past(toggle_q))); // R4
  AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(toggle_q)); // R4
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst) tick |=> (tcnt == TCNT_W'($past(tcnt) + 1'b1))); // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(tcnt)); // R6
  AST_RD_HIT: assert property (@(posedge clk) disable iff (rst) (rd_stb && rd_addr == CNT_ADDR) |=> (rd_data == DATA_W'($past(tcnt)))); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst) !rd_stb |=> $stable(rd_data)); // R7
  AST_RD_MISS: assert property (@(posedge clk) disable iff (rst) (rd_stb && rd_addr != CNT_ADDR) |=> (rd_data == '0)); // R8
endmodule

bind tick_toggle_timer tick_toggle_timer_chk #(
  .PRE_W(PRE_W), .TCNT_W(TCNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_ADDR(CNT_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .rd_stb(rd_stb), .rd_addr(rd_addr),
  .tick(tick), .toggle_q(toggle_q), .pre(pre), .tcnt(tcnt), .rd_data(rd_data)
);

// File: tb/tb_tick_toggle_timer.sv
module tb_tick_toggle_timer;
  localparam int PRE_W  = 4;
  localparam int TCNT_W = 6;
  localparam logic [7:0] HIT = 8'h30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_en = 1'b0, rd_stb = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [5:0] ip_in = '0;
  logic tick;
  logic [5:0] ip_out;
  logic [15:0] rd_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  int m_pre = 0, m_cnt = 0, m_rd = 0;
  bit m_tog = 0, prev_tick = 0;

  always #5 clk = ~clk;

  tick_toggle_timer #(.PRE_W(PRE_W), .TCNT_W(TCNT_W)) dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .ip_in(ip_in), .tick(tick), .ip_out(ip_out), .rd_data(rd_data)
  );

  function automatic bit exp_tick(int pre, bit en);
    return en && (pre == (1 << PRE_W) - 1);
  endfunction

  function automatic int wrap_inc(int v, int w);
    return (v + 1) % (1 << w);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check, then advance model at posedge
  task automatic cyc(bit r, bit en, bit stb, logic [7:0] a, logic [5:0] ip);
    bit t;
    @(negedge clk);
    rst = r; cnt_en = en; rd_stb = stb; rd_addr = a; ip_in = ip;
    #1;
    t = exp_tick(m_pre, en);
    chk("R2 tick", int'(tick), int'(t));
    chk("R3 no back-to-back tick", int'(tick && prev_tick), 0);
    chk("R4 toggle level", int'(ip_out[2]), int'(m_tog));
    chk("R5 pass-through", int'({ip_out[5:3], ip_out[1:0]}), int'({ip[5:3], ip[1:0]}));
    chk("R7 rd_data", int'(rd_data), m_rd);
    prev_tick = tick;
    @(posedge clk);
    if (r) begin
      m_pre = 0; m_cnt = 0; m_tog = 0; m_rd = 0;
    end else begin
      if (stb) m_rd = (a == HIT) ? m_cnt : 0;
      if (en) m_pre = wrap_inc(m_pre, PRE_W);
      if (t) begin
        m_tog = ~m_tog;
        m_cnt = wrap_inc(m_cnt, TCNT_W);
      end
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (2) @(posedge clk);
    // R1: reset state
    @(negedge clk);
    chk("R1 toggle after reset", int'(ip_out[2]), 0);
    chk("R1 rd_data after reset", int'(rd_data), 0);
    chk("R1 no tick after reset", int'(tick), 0);
    // R1/R2: first tick after exactly 2^PRE_W enabled cycles, read count 1
    for (int i = 0; i < (1 << PRE_W); i++) cyc(0, 1, 0, HIT, 6'h15);
    cyc(0, 0, 1, HIT, 6'h2a);
    cyc(0, 0, 0, HIT, 6'h00);
    chk("R1 first tick counted", int'(rd_data), 1);
    // R3: enable held high across several wraps
    for (int i = 0; i < 40; i++) cyc(0, 1, 0, 8'h00, 6'h3f);
    // R2: enable low, nothing advances
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 8'h00, 6'h0f);
    // R8: miss address returns zero
    cyc(0, 0, 1, 8'h31, 6'h00);
    cyc(0, 0, 0, 8'h00, 6'h00);
    chk("R8 miss read", int'(rd_data), 0);
    // random traffic, enough ticks to wrap the counter (R6)
    for (int i = 0; i < 4000; i++) begin
      bit en = ($urandom % 10) < 8;
      bit stb = ($urandom % 4) == 0;
      logic [7:0] a = (($urandom % 3) != 0) ? HIT : 8'($urandom);
      cyc(0, en, stb, a, 6'($urandom));
    end
    // R6: explicit read after wraps matches model count
    cyc(0, 0, 1, HIT, 6'h00);
    cyc(0, 0, 0, HIT, 6'h00);
    chk("R6 count after wrap", int'(rd_data), m_cnt);
    // R1: reset mid-run
    cyc(1, 1, 0, HIT, 6'h00);
    @(negedge clk);
    chk("R1 toggle cleared", int'(ip_out[2]), 0);
    chk("R1 rd_data cleared", int'(rd_data), 0);
    cyc(0, 0, 1, HIT, 6'h00);
    cyc(0, 0, 0, HIT, 6'h00);
    chk("R1 count cleared", int'(rd_data), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule